// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address stream for a single SDRAM read or write burst. A one-cycle start pulse carries the first column, a burst-length code and an order select. From the next cycle on, the block presents one column address per clock, together with a valid flag. A last flag marks the final beat of a burst of fixed length.

For fixed lengths the address stays inside the aligned block that the burst size defines. The upper column bits stay constant. The low bits step either by addition modulo the length (sequential order) or as the start's low bits XOR the beat index (interleaved order). A full-page burst walks the whole row, wrapping from the top column back to zero, and runs until a terminate strobe or a new start arrives. A start may arrive on any cycle and replaces whatever burst is running.

Top module: `sdram_col_burst`

## Requirements
- R1: While reset is high, and after it until the first start, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: In the cycle after a start pulse, `valid_o` is 1 and `col_o` equals the start column captured with that pulse.
- R3: The length code on `blen_i` gives these burst lengths: 3'b000 is 1 beat, 3'b001 is 2, 3'b010 is 4, 3'b011 is 8, and 3'b111 is full page. Every other code behaves as 1 beat. A fixed-length burst shows exactly that many valid beats, and then `valid_o` drops.
- R4: With `ilv_i` = 0 and length L in {2,4,8}, beat k (counting from 0) has its low log2(L) bits equal to (start low bits + k) mod L. The remaining upper bits equal the start's upper bits.
- R5: With `ilv_i` = 1 and length L in {2,4,8}, beat k has its low log2(L) bits equal to start low bits XOR k. The upper bits are unchanged.
- R6: In full-page mode, beat k is (start + k) mod 512 and continues with no end of its own. `ilv_i` has no effect in this mode.
- R7: `last_o` is 1 only together with the final valid beat of a fixed-length burst. It is never 1 in full-page mode.
- R8: A terminate strobe without a start makes `valid_o` 0 from the next cycle.
- R9: A start during a running burst restarts the sequence from the new column with the new mode. A start in the same cycle as a terminate takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures column and mode |
| start_col_i | input | 9 | First column of the burst |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 sequential, 1 interleaved order |
| term_i | input | 1 | Ends the running burst |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | Column address is a live beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Bursts start at columns with nonzero low bits. This makes sequential and interleaved orders give different sequences, and it shows whether the wrap stays inside the aligned block or carries into the upper bits. Every length code is tried, including a reserved one, in both orders. A full-page run starts near the top column so that the wrap to zero is seen, and it has interleave requested to confirm that the request is ignored. Restarts in mid-burst and a start coinciding with a terminate separate the priority of start from the early stop.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    localparam int COL_W   = 9;
    localparam int CODE_W  = 3;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_PAGE = 3'b111;

    typedef struct packed {
        logic active;
        logic page;
        logic ilv;
        col_t base;
        col_t mask;
        col_t cnt;
    } burst_state_t;

    // Mask of the address bits that move within one burst.
    function automatic col_t len_mask(code_t code);
        case (code)
            3'b001:    return col_t'(1);
            3'b010:    return col_t'(3);
            3'b011:    return col_t'(7);
            CODE_PAGE: return '1;
            default:   return '0;
        endcase
    endfunction

    // Address of beat cnt within the block selected by mask.
    function automatic col_t beat_addr(col_t base, col_t mask, col_t cnt, logic ilv);
        col_t low;
        low = ilv ? ((base ^ cnt) & mask) : ((base + cnt) & mask);
        return (base & ~mask) | low;
    endfunction

endpackage

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  col_t         start_col_i,
    input  code_t        blen_i,
    input  logic         ilv_i,
    input  logic         term_i,
    output burst_state_t st_o,
    output logic         last_o
);

    burst_state_t st_q;
    logic         at_end;

    assign at_end = !st_q.page && (st_q.cnt == st_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (start_i) begin
            st_q.active <= 1'b1;
            st_q.page   <= (blen_i == CODE_PAGE);
            st_q.ilv    <= ilv_i && (blen_i != CODE_PAGE);
            st_q.base   <= start_col_i;
            st_q.mask   <= len_mask(blen_i);
            st_q.cnt    <= '0;
        end else if (term_i) begin
            st_q.active <= 1'b0;
        end else if (st_q.active) begin
            if (at_end) st_q.active <= 1'b0;
            else        st_q.cnt    <= st_q.cnt + col_t'(1);
        end
    end

    assign st_o   = st_q;
    assign last_o = st_q.active && at_end;

    // R8: a terminate without a start stops the burst
    p_term_stop_r8: assert property (@(posedge clk) disable iff (rst)
        term_i && !start_i |=> !st_q.active);

    // R7: full-page bursts never flag a last beat
    p_page_no_last_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.page |-> !last_o);

    // R3: after the last beat the burst is over unless restarted
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        last_o && !start_i |=> !st_q.active);

    // R9: a start wins over a terminate in the same cycle
    p_start_wins_r9: assert property (@(posedge clk) disable iff (rst)
        start_i && term_i |=> st_q.active && st_q.cnt == '0);

endmodule

// File: rtl/sdram_burst_addr.sv
module sdram_burst_addr
    import sdram_burst_pkg::*;
(
    input  burst_state_t st_i,
    output col_t         col_o
);

    assign col_o = beat_addr(st_i.base, st_i.mask, st_i.cnt, st_i.ilv);

endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
    import sdram_burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [8:0]   start_col_i,
    input  logic [2:0]   blen_i,
    input  logic         ilv_i,
    input  logic         term_i,
    output logic [8:0]   col_o,
    output logic         valid_o,
    output logic         last_o
);

    burst_state_t st;
    col_t         addr;

    sdram_burst_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .ilv_i       (ilv_i),
        .term_i      (term_i),
        .st_o        (st),
        .last_o      (last_o)
    );

    sdram_burst_addr u_addr (
        .st_i  (st),
        .col_o (addr)
    );

    assign col_o   = addr;
    assign valid_o = st.active;

    // R2: first beat shows the captured column
    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o && col_o == $past(start_col_i));

    // R4: upper bits hold while a burst keeps running
    p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o && !last_o && !start_i && !term_i |=>
        valid_o && ((col_o & ~st.mask) == ($past(col_o) & ~st.mask)));

    // R7: last only on a valid beat
    p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

endmodule

// File: tb/tb_sdram_col_burst.sv
module tb_sdram_col_burst;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    always #5 clk = ~clk;

    sdram_col_burst dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // reference model state
    int m_active = 0, m_base = 0, m_len = 1, m_page = 0, m_ilv = 0, m_k = 0;

    function automatic int exp_addr();
        int len, upper, lo;
        len   = m_page ? 512 : m_len;
        upper = (m_base / len) * len;
        lo    = m_base % len;
        if (m_ilv != 0 && m_page == 0) lo = lo ^ m_k;
        else                           lo = (lo + m_k) % len;
        return upper + lo;
    endfunction

    function automatic int code_len(logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_active = 0; m_k = 0;
        end else if (start_i) begin
            m_active = 1; m_base = start_col_i; m_k = 0;
            m_page = (blen_i == 3'b111);
            m_len  = code_len(blen_i);
            m_ilv  = ilv_i;
        end else if (term_i) begin
            m_active = 0;
        end else if (m_active != 0) begin
            if (m_page == 0 && m_k == m_len - 1) m_active = 0;
            else m_k = (m_k + 1) % 512;
        end
    end

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int ev, el;
            ev = m_active;
            el = (m_active != 0 && m_page == 0 && m_k == m_len - 1) ? 1 : 0;
            check("valid", int'(valid_o), ev);
            check("last", int'(last_o), el);
            if (ev != 0) check("col", int'(col_o), exp_addr());
            if (cur_req == "R1") check("col at reset", int'(col_o), 0);
        end
    end

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles == 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            start_i = 1'b0; term_i = 1'b0;
        end
    endtask

    task automatic launch(string req, int col, logic [2:0] code, logic ilv);
        @(posedge clk); #1;
        cur_req = req;
        start_i = 1'b1; term_i = 1'b0;
        start_col_i = 9'(col); blen_i = code; ilv_i = ilv;
    endtask

    task automatic stop_now();
        @(posedge clk); #1;
        start_i = 1'b0; term_i = 1'b1;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(3);

        // R4 / R3 / R7: sequential wrap inside aligned block of 8
        launch("R4", 9'h1D, 3'b011, 1'b0); step(10);
        // R5: interleaved, same start
        launch("R5", 9'h1D, 3'b011, 1'b1); step(10);
        launch("R4", 9'h0A3, 3'b010, 1'b0); step(6);
        launch("R5", 9'h0A3, 3'b010, 1'b1); step(6);
        launch("R5", 9'h157, 3'b001, 1'b1); step(4);
        launch("R4", 9'h157, 3'b001, 1'b0); step(4);
        // R3: single beat and a reserved code
        launch("R3", 9'h1FF, 3'b000, 1'b1); step(3);
        launch("R3", 9'h042, 3'b101, 1'b0); step(3);
        // R6: full page near the top, interleave requested, then R8 stop
        launch("R6", 508, 3'b111, 1'b1); step(12);
        cur_req = "R8";
        stop_now(); step(3);
        // R9: restart mid-burst with a different mode
        launch("R9", 9'h0F1, 3'b011, 1'b0); step(3);
        launch("R9", 9'h132, 3'b010, 1'b1); step(2);
        // R9: start together with terminate
        @(posedge clk); #1;
        start_i = 1'b1; term_i = 1'b1; start_col_i = 9'h066; blen_i = 3'b011; ilv_i = 1'b1;
        step(10);
        // R8: terminate in mid-burst
        launch("R8", 9'h0C4, 3'b011, 1'b0); step(2);
        stop_now(); step(4);
        // R7: back-to-back bursts, start on the last beat
        launch("R7", 9'h011, 3'b001, 1'b0); step(1);
        launch("R7", 9'h1F0, 3'b111, 1'b0); step(20);
        stop_now(); step(3);

        @(negedge clk);
        summary();
    end

endmodule